// File: doc/BRIEF.md
# Clocked-Shift Serial Master Port

This block is the synchronous, shift-register mode of a serial I/O port, where the block is always the clock master. It drives a shift clock on one pin and a single data line that serves both directions. In transmit it sends one byte, least significant bit first. In receive it takes eight bits from the same data line into a receive byte. The data line is split into an output value, an output enable and an input value, so that a pad or tristate buffer at the chip edge can join them.

All timing comes from the core clock, which is taken to be the oscillator clock. A free-running phase counter splits every shift-clock period into a low half and a high half. A transfer waits for the next period boundary before it starts, so every clock pulse it makes has the full width. Transmit bytes enter through a valid/ready stream port. A byte is taken on the cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is low for the whole of any transfer, so a source that holds `tx_valid` simply waits. Received bytes leave through a valid/ready stream port. `rx_valid` stays high and `rx_data` stays frozen until the consumer raises `rx_ready`. While a byte is still unread, no new receive can start, which is how back-pressure reaches the line. Start, completion and clear pins are plain level or pulse signals.

Top module: `ssp_sync_master`

## Requirements
- R1: After reset, and whenever no transfer is in progress, `sclk` is 1, `sd_oe` is 0, `tx_ready` is 1, and `tx_done` and `rx_valid` are 0 until a transfer completes.
- R2: Each transfer makes exactly 8 pulses on `sclk`. Each low phase lasts 4 core cycles, and each high phase between two pulses lasts 4 core cycles.
- R3: In transmit, the value of `sd_o` seen at the k-th rising edge of `sclk` (k = 0..7) is bit k of the accepted byte, so bit 0 goes first.
- R4: During transmit, `sd_o` changes only in the core cycle that comes 2 cycles after a rising edge of `sclk` becomes visible. It is never changed at or right after the edge.
- R5: `sd_oe` goes high in transmit only, at the first falling edge, and drops exactly 5 core cycles after the eighth rising edge. It stays 0 for the whole of a receive.
- R6: In receive, `sd_i` is captured at each rising edge of `sclk`. The bit captured at the k-th edge becomes bit k of `rx_data`.
- R7: `tx_done` becomes 1 in the same cycle that the eighth rising edge of a transmit appears on `sclk`. It then holds until a cycle with `tx_done_clr` high clears it.
- R8: `rx_valid` becomes 1 in the same cycle that the eighth rising edge of a receive appears. It then holds, with `rx_data` unchanged, until a cycle with `rx_ready` high.
- R9: `tx_ready` is 0 from the cycle after a start is taken until the cycle `sd_oe` is released. A `rx_start` pulse is ignored while a transfer is running, while `rx_valid` is 1, or when `tx_valid` is high in the same cycle.
- R10: The first falling edge of `sclk` appears no later than 9 core cycles after the start is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, equal to the oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Port is idle and takes a byte or a start |
| tx_data | input | 8 | Byte to transmit |
| tx_done | output | 1 | Transmit completion flag |
| tx_done_clr | input | 1 | Clears `tx_done` |
| rx_start | input | 1 | Pulse that starts a receive |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | 8 | Received byte |
| sclk | output | 1 | Shift clock, idles high |
| sd_o | output | 1 | Data line output value |
| sd_oe | output | 1 | Data line output enable |
| sd_i | input | 1 | Data line input value |

## Verification
The properties assume that `sd_i` is already stable at the core edge where the rising edge of `sclk` is made, because the port samples it without a synchronizer. The stimulus changes `sd_i` only just after a falling edge of `sclk`, which leaves three core cycles of margin. The properties also assume that consumers drive `rx_ready` and `tx_done_clr` as single-cycle pulses when they use them. The sweeps send and receive all 256 byte values. The stimulus raises starts only through the documented handshakes, except in the deliberate cases that check that a start is ignored.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TAIL  = 2'd3
  } ssp_state_e;
endpackage

// File: rtl/ssp_phase_gen.sv
// Free-running phase counter over one shift-clock period, with strobes
// marking the core edges where the clock rises, falls, and data is launched.
module ssp_phase_gen #(
  parameter int HALF = 4,
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rise_stb,
  output logic fall_stb,
  output logic launch_stb
);
  localparam int PER  = 2 * HALF;
  localparam int PH_W = (PER > 2) ? $clog2(PER) : 1;
  localparam logic [PH_W-1:0] LAST_PH   = PH_W'(PER - 1);
  localparam logic [PH_W-1:0] RISE_PH   = PH_W'(HALF - 1);
  localparam logic [PH_W-1:0] LAUNCH_PH = PH_W'(HALF + HOLD - 1);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else if (ph_q == LAST_PH) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  always_comb begin
    rise_stb   = (ph_q == RISE_PH);
    fall_stb   = (ph_q == LAST_PH);
    launch_stb = (ph_q == LAUNCH_PH);
  end
endmodule

// File: rtl/ssp_seq.sv
// Transfer sequencer: waits for a period boundary, drives the shift clock,
// counts bits, and holds the data line after the last edge before release.
module ssp_seq
  import ssp_pkg::*;
#(
  parameter int BITS = 8,
  parameter int REL  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_stb,
  input  logic fall_stb,
  input  logic launch_stb,
  input  logic start_tx,
  input  logic start_rx,
  output logic idle,
  output logic sclk,
  output logic sd_oe,
  output logic shift_tx,
  output logic sample_rx,
  output logic done,
  output logic done_is_tx
);
  localparam int CNT_W  = (BITS > 2) ? $clog2(BITS) : 1;
  localparam int TAIL_W = (REL > 1) ? $clog2(REL + 1) : 1;
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BITS - 1);
  localparam logic [TAIL_W-1:0] TAIL_END = TAIL_W'(REL - 1);

  ssp_state_e        state_q;
  logic              mode_tx_q;
  logic              sclk_q;
  logic              oe_q;
  logic [CNT_W-1:0]  bit_q;
  logic [TAIL_W-1:0] tail_q;
  logic              last_edge;

  assign last_edge = (state_q == ST_SHIFT) && rise_stb && (bit_q == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      mode_tx_q <= 1'b0;
      sclk_q    <= 1'b1;
      oe_q      <= 1'b0;
      bit_q     <= '0;
      tail_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_tx) begin
            state_q   <= ST_WAIT;
            mode_tx_q <= 1'b1;
          end else if (start_rx) begin
            state_q   <= ST_WAIT;
            mode_tx_q <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (fall_stb) begin
            state_q <= ST_SHIFT;
            sclk_q  <= 1'b0;
            bit_q   <= '0;
            oe_q    <= mode_tx_q;
          end
        end
        ST_SHIFT: begin
          if (rise_stb) begin
            sclk_q <= 1'b1;
            if (bit_q == LAST_BIT) begin
              state_q <= ST_TAIL;
              tail_q  <= '0;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end else if (fall_stb) begin
            sclk_q <= 1'b0;
          end
        end
        ST_TAIL: begin
          if (tail_q == TAIL_END) begin
            state_q <= ST_IDLE;
            oe_q    <= 1'b0;
          end else begin
            tail_q <= tail_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    idle       = (state_q == ST_IDLE);
    sclk       = sclk_q;
    sd_oe      = oe_q;
    shift_tx   = (state_q == ST_SHIFT) && launch_stb && mode_tx_q;
    sample_rx  = (state_q == ST_SHIFT) && rise_stb && !mode_tx_q;
    done       = last_edge;
    done_is_tx = mode_tx_q;
  end
endmodule

// File: rtl/ssp_shifter.sv
// Transmit and receive shift registers, both least significant bit first.
module ssp_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_load,
  input  logic [BITS-1:0] tx_byte,
  input  logic            shift_tx,
  input  logic            sample_rx,
  input  logic            rx_commit,
  input  logic            sd_i,
  output logic            sd_o,
  output logic [BITS-1:0] rx_byte
);
  logic [BITS-1:0] tx_sr_q;
  logic [BITS-1:0] rx_sr_q;
  logic [BITS-1:0] rx_next;
  logic [BITS-1:0] rx_hold_q;

  generate
    if (BITS > 1) begin : g_wide
      assign rx_next = {sd_i, rx_sr_q[BITS-1:1]};
    end else begin : g_one
      assign rx_next = sd_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr_q <= '0;
    end else if (tx_load) begin
      tx_sr_q <= tx_byte;
    end else if (shift_tx) begin
      tx_sr_q <= tx_sr_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr_q   <= '0;
      rx_hold_q <= '0;
    end else begin
      if (sample_rx) begin
        rx_sr_q <= rx_next;
      end
      if (rx_commit) begin
        rx_hold_q <= rx_next;
      end
    end
  end

  assign sd_o    = tx_sr_q[0];
  assign rx_byte = rx_hold_q;
endmodule

// File: rtl/ssp_sync_master.sv
module ssp_sync_master #(
  parameter int BITS = 8,
  parameter int HALF = 4,
  parameter int HOLD = 2,
  parameter int REL  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_valid,
  output logic            tx_ready,
  input  logic [BITS-1:0] tx_data,
  output logic            tx_done,
  input  logic            tx_done_clr,
  input  logic            rx_start,
  output logic            rx_valid,
  input  logic            rx_ready,
  output logic [BITS-1:0] rx_data,
  output logic            sclk,
  output logic            sd_o,
  output logic            sd_oe,
  input  logic            sd_i
);
  logic rise_stb, fall_stb, launch_stb;
  logic idle, start_tx, start_rx;
  logic shift_tx, sample_rx, done, done_is_tx;
  logic tx_done_q, rx_valid_q;

  assign start_tx = tx_valid && idle;
  assign start_rx = rx_start && idle && !tx_valid && !rx_valid_q;

  ssp_phase_gen #(.HALF(HALF), .HOLD(HOLD)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_stb   (rise_stb),
    .fall_stb   (fall_stb),
    .launch_stb (launch_stb)
  );

  ssp_seq #(.BITS(BITS), .REL(REL)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_stb   (rise_stb),
    .fall_stb   (fall_stb),
    .launch_stb (launch_stb),
    .start_tx   (start_tx),
    .start_rx   (start_rx),
    .idle       (idle),
    .sclk       (sclk),
    .sd_oe      (sd_oe),
    .shift_tx   (shift_tx),
    .sample_rx  (sample_rx),
    .done       (done),
    .done_is_tx (done_is_tx)
  );

  ssp_shifter #(.BITS(BITS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_load   (start_tx),
    .tx_byte   (tx_data),
    .shift_tx  (shift_tx),
    .sample_rx (sample_rx),
    .rx_commit (done && !done_is_tx),
    .sd_i      (sd_i),
    .sd_o      (sd_o),
    .rx_byte   (rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_done_q  <= 1'b0;
      rx_valid_q <= 1'b0;
    end else begin
      if (done && done_is_tx) begin
        tx_done_q <= 1'b1;
      end else if (tx_done_clr) begin
        tx_done_q <= 1'b0;
      end
      if (done && !done_is_tx) begin
        rx_valid_q <= 1'b1;
      end else if (rx_ready) begin
        rx_valid_q <= 1'b0;
      end
    end
  end

  assign tx_ready = idle;
  assign tx_done  = tx_done_q;
  assign rx_valid = rx_valid_q;
endmodule

// File: rtl/ssp_sync_master_chk.sv
module ssp_sync_master_chk #(
  parameter int BITS = 8,
  parameter int HALF = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sclk,
  input logic            sd_o,
  input logic            sd_oe,
  input logic            tx_ready,
  input logic            tx_done,
  input logic            tx_done_clr,
  input logic            rx_valid,
  input logic            rx_ready,
  input logic [BITS-1:0] rx_data
);
  logic [7:0] low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q <= '0;
    end else if (sclk) begin
      low_run_q <= '0;
    end else if (low_run_q != 8'hFF) begin
      low_run_q <= low_run_q + 1'b1;
    end
  end

  p_idle_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (sclk && !sd_oe));

  p_low_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (low_run_q == 8'(HALF)));

  p_hold_after_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk) && sd_oe) |=> $stable(sd_o));

  p_drive_when_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe |-> !tx_ready);

  p_txdone_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> $rose(sclk));

  p_txdone_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !tx_done_clr) |=> tx_done);

  p_rxvalid_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $rose(sclk));

  p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
endmodule

bind ssp_sync_master ssp_sync_master_chk #(.BITS(BITS), .HALF(HALF)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sclk        (sclk),
  .sd_o        (sd_o),
  .sd_oe       (sd_oe),
  .tx_ready    (tx_ready),
  .tx_done     (tx_done),
  .tx_done_clr (tx_done_clr),
  .rx_valid    (rx_valid),
  .rx_ready    (rx_ready),
  .rx_data     (rx_data)
);

// File: tb/ssp_sync_master_tb.sv
`timescale 1ns/1ps
module ssp_sync_master_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = '0;
  logic       tx_done;
  logic       tx_done_clr = 1'b0;
  logic       rx_start = 1'b0;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       sclk, sd_o, sd_oe;
  logic       sd_i = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  ssp_sync_master u_dut (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_done(tx_done), .tx_done_clr(tx_done_clr),
    .rx_start(rx_start), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .sclk(sclk), .sd_o(sd_o), .sd_oe(sd_oe), .sd_i(sd_i)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_tx(input logic [7:0] d);
    logic [7:0] got = '0;
    logic prev_s = 1'b1, prev_oe = 1'b0, prev_d = 1'b0, s;
    int run = 100, rises = 0, since = 99, waited = 1;
    bit seen_fall = 0, fin = 0;
    while (!tx_ready) @(negedge clk);
    tx_data = d; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(!tx_ready, "R9 ready low while busy", tx_ready, 0);
    for (int c = 0; c < 300 && !fin; c++) begin
      s = sclk;
      if (!seen_fall && !s) begin
        seen_fall = 1;
        chk(waited <= 9, "R10 start latency", waited, 9);
      end
      if (s != prev_s) begin
        if (s && rises < 8) chk(run == 4, "R2 low width", run, 4);
        if (!s && rises > 0) chk(run == 4, "R2 high width", run, 4);
        run = 1;
      end else run++;
      if (s && !prev_s) begin
        got[rises] = sd_o;
        rises++;
        since = 0;
        if (rises == 8) chk(tx_done == 1'b1, "R7 done at eighth edge", tx_done, 1);
      end else since++;
      if (sd_oe && prev_oe && (sd_o != prev_d)) chk(since == 2, "R4 launch delay", since, 2);
      if (prev_oe && !sd_oe) begin
        chk(rises == 8 && since == 5, "R5 release delay", since, 5);
        fin = 1;
      end
      prev_s = s; prev_oe = sd_oe; prev_d = sd_o;
      if (!fin) begin
        @(negedge clk);
        waited++;
      end
    end
    chk(fin, "R5 line released", fin, 1);
    chk(rises == 8, "R2 pulse count", rises, 8);
    chk(got == d, "R3 transmit order", got, d);
    chk(tx_ready, "R9 ready on release", tx_ready, 1);
    @(negedge clk);
    chk(tx_done, "R7 done holds", tx_done, 1);
    tx_done_clr = 1'b1;
    @(negedge clk);
    tx_done_clr = 1'b0;
    chk(!tx_done, "R7 clear", tx_done, 0);
  endtask

  task automatic do_rx(input logic [7:0] d, input bit ign);
    logic prev_s = 1'b1, s;
    int rises = 0, falls = 0;
    bit oe_seen = 0, fin = 0, pulsed = 0, hi_all = 1;
    while (!tx_ready) @(negedge clk);
    rx_start = 1'b1;
    @(negedge clk);
    rx_start = 1'b0;
    chk(!tx_ready, "R9 busy after receive start", tx_ready, 0);
    for (int c = 0; c < 300 && !fin; c++) begin
      rx_start = 1'b0;
      s = sclk;
      if (sd_oe) oe_seen = 1;
      if (prev_s && !s) begin
        if (falls < 8) sd_i = d[falls];
        falls++;
      end
      if (s && !prev_s) begin
        rises++;
        if (rises == 8) begin
          chk(rx_valid, "R8 valid at eighth edge", rx_valid, 1);
          chk(rx_data == d, "R6 receive order", rx_data, d);
        end
        if (rises == 3 && ign && !pulsed) begin
          rx_start = 1'b1;
          pulsed = 1;
        end
      end
      if (tx_ready && rises == 8) fin = 1;
      prev_s = s;
      if (!fin) @(negedge clk);
    end
    rx_start = 1'b0;
    chk(fin && rises == 8, "R2 receive pulse count", rises, 8);
    chk(!oe_seen, "R5 no drive in receive", oe_seen, 0);
    if (ign) begin
      rx_start = 1'b1;
      @(negedge clk);
      rx_start = 1'b0;
      for (int k = 0; k < 20; k++) begin
        if (!sclk) hi_all = 0;
        @(negedge clk);
      end
      chk(hi_all && tx_ready, "R9 start ignored while byte unread", hi_all, 1);
      chk(rx_valid && rx_data == d, "R8 byte held", rx_data, d);
    end
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk(!rx_valid, "R8 handshake clears", rx_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sclk, "R1 clock idles high", sclk, 1);
    chk(!sd_oe, "R1 line released", sd_oe, 0);
    chk(tx_ready, "R1 ready", tx_ready, 1);
    chk(!tx_done, "R1 tx flag clear", tx_done, 0);
    chk(!rx_valid, "R1 rx flag clear", rx_valid, 0);
    for (int i = 0; i < 256; i++) do_tx(8'(i));
    for (int i = 0; i < 256; i++) do_rx(8'(i), (i % 64) == 5);
    do_tx(8'hA5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule